// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the datapath half of a small accumulator machine. It has a 4-bit program counter, a 4-bit memory address register, an 8-bit instruction register, a 16-word by 8-bit RAM, an 8-bit accumulator, an 8-bit temporary register and an 8-bit adder. All of them hang off one shared 8-bit bus. The datapath has no sequencing of its own. An external controller raises one-bit strobes, and each clock edge performs the register transfers those strobes select. A fetch is two such steps, and so is a load-accumulator. A conditional jump or a no-op is one step.

The datapath returns the instruction's 4-bit opcode and a registered zero flag to the controller. The controller uses them to choose its next step. A separate test port writes RAM words directly so that a program can be placed in memory. The shared bus is also brought out as an output, so that any register can be read back by driving it onto the bus.

Top module: `accbus_datapath`

## Requirements
- R1: A synchronous reset clears the program counter, MAR, instruction register, accumulator, temporary register and zero flag. RAM contents are left unchanged.
- R2: When exactly one bus driver is asserted, the bus carries that source's value. The program counter and the instruction address field IR[3:0] are zero-extended in the upper bits. When no driver is asserted, the bus reads 0.
- R3: If two or more of the drivers (program counter, RAM, accumulator, adder, IR address field) are asserted together, bus_conflict goes to 1 and the bus reads 0 in that cycle.
- R4: With pc_jump set, the program counter takes bus[3:0]. Otherwise, with the increment strobe set, it adds 1 and wraps from 15 to 0. pc_jump wins when both are set. With neither set, the program counter holds.
- R5: The MAR load strobe captures bus[3:0], and the IR load strobe captures the bus. opcode always shows IR[7:4], and IR[3:0] is the address field.
- R6: The RAM driver puts RAM[MAR] on the bus. The RAM write strobe stores the bus value into RAM[MAR] at the clock edge.
- R7: When load_en is set, load_data is written to RAM[load_addr]. This write takes priority over a strobed RAM write in the same cycle.
- R8: The accumulator load strobe captures the bus into the accumulator. At the same edge, zero_flag is set to 1 if the loaded value is 0 and cleared otherwise. Without that strobe, both hold their values.
- R9: The temporary load strobe captures the bus. The adder driver puts (accumulator + temporary) mod 256 on the bus.
- R10: The strobe word uses these bit positions: bit 9 PC drive, 8 PC increment, 7 MAR load, 6 RAM drive, 5 RAM write, 4 IR load, 3 ACC load, 2 ACC drive, 1 TEMP load, 0 adder drive.
- R11: Strobe sequences compose into working instructions:
  - A fetch is PC drive with MAR load, then RAM drive with IR load.
  - A load-accumulator is IR address drive with MAR load, then RAM drive with ACC load and PC increment.
  - A taken jump is IR address drive with pc_jump.
  - A no-op is PC increment alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 10 | Packed transfer strobes (bit positions in R10) |
| ir_field_drv | input | 1 | Drive IR[3:0], zero-extended, onto the bus |
| pc_jump | input | 1 | Load program counter from bus[3:0] |
| load_en | input | 1 | Test-port RAM write enable |
| load_addr | input | 4 | Test-port RAM address |
| load_data | input | 8 | Test-port RAM data |
| opcode | output | 4 | IR[7:4] to the controller |
| zero_flag | output | 1 | Set when the last accumulator load was zero |
| bus_conflict | output | 1 | More than one bus driver asserted |
| bus_value | output | 8 | Current shared bus value |

## Verification
Several behaviours are checked by assertions on every cycle:
- the program counter holds when neither of its strobes is set, and wraps from 15 to 0;
- MAR and IR capture the bus;
- a RAM write lands at the address MAR held;
- zero_flag agrees with the accumulator after each load.

Other behaviours can only be shown by the bench's scenarios:
- a whole instruction stream composed from strobes;
- the adder's wrap modulo 256;
- the bus reading zero and the accumulator capturing zero when drivers collide;
- RAM keeping its contents across reset;
- the test port winning over a strobed write.

// File: rtl/accbus_datapath.sv
module accbus_datapath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [9:0]        strobe,
  input  logic              ir_field_drv,
  input  logic              pc_jump,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-ADDR_W-1:0] opcode,
  output logic              zero_flag,
  output logic              bus_conflict,
  output logic [DATA_W-1:0] bus_value
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = DATA_W - ADDR_W;

  localparam int B_PC_DRV  = 9;
  localparam int B_PC_STEP = 8;
  localparam int B_MAR_LD  = 7;
  localparam int B_MEM_DRV = 6;
  localparam int B_MEM_WR  = 5;
  localparam int B_IR_LD   = 4;
  localparam int B_ACC_LD  = 3;
  localparam int B_ACC_DRV = 2;
  localparam int B_TMP_LD  = 1;
  localparam int B_SUM_DRV = 0;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] ir, acc, tmp, sum;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bus_mux;
  logic [4:0]        drv;

  assign sum    = acc + tmp;
  assign opcode = ir[DATA_W-1:ADDR_W];
  assign drv    = {strobe[B_PC_DRV], strobe[B_MEM_DRV], strobe[B_ACC_DRV],
                   strobe[B_SUM_DRV], ir_field_drv};
  assign bus_conflict = ($countones(drv) > 1);

  always_comb begin
    bus_mux = '0;
    if (strobe[B_PC_DRV])  bus_mux = bus_mux | {{PAD_W{1'b0}}, pc};
    if (strobe[B_MEM_DRV]) bus_mux = bus_mux | mem[mar];
    if (strobe[B_ACC_DRV]) bus_mux = bus_mux | acc;
    if (strobe[B_SUM_DRV]) bus_mux = bus_mux | sum;
    if (ir_field_drv)      bus_mux = bus_mux | {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
  end

  assign bus_value = bus_conflict ? '0 : bus_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      mar       <= '0;
      ir        <= '0;
      acc       <= '0;
      tmp       <= '0;
      zero_flag <= 1'b0;
    end else begin
      if (pc_jump)                pc <= bus_value[ADDR_W-1:0];
      else if (strobe[B_PC_STEP]) pc <= pc + 1'b1;
      if (strobe[B_MAR_LD]) mar <= bus_value[ADDR_W-1:0];
      if (strobe[B_IR_LD])  ir  <= bus_value;
      if (strobe[B_TMP_LD]) tmp <= bus_value;
      if (strobe[B_ACC_LD]) begin
        acc       <= bus_value;
        zero_flag <= (bus_value == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_en)               mem[load_addr] <= load_data;
    else if (strobe[B_MEM_WR]) mem[mar]       <= bus_value;
  end

  a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!pc_jump && !strobe[B_PC_STEP]) |=> (pc == $past(pc)));

  a_r4_pc_wrap: assert property (@(posedge clk) disable iff (rst)
    (!pc_jump && strobe[B_PC_STEP] && pc == {ADDR_W{1'b1}}) |=> (pc == '0));

  a_r5_mar_capture: assert property (@(posedge clk) disable iff (rst)
    strobe[B_MAR_LD] |=> (mar == $past(bus_value[ADDR_W-1:0])));

  a_r5_opcode_capture: assert property (@(posedge clk) disable iff (rst)
    strobe[B_IR_LD] |=> (opcode == $past(bus_value[DATA_W-1:ADDR_W])));

  a_r8_zero_tracks_acc: assert property (@(posedge clk) disable iff (rst)
    strobe[B_ACC_LD] |=> (zero_flag == (acc == '0)));

  a_r6_mem_write: assert property (@(posedge clk) disable iff (rst)
    (strobe[B_MEM_WR] && !load_en) |=> (mem[$past(mar)] == $past(bus_value)));
endmodule

// File: tb/test_accbus_datapath.sv
module test_accbus_datapath;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] strobe = '0;
  logic       ir_field_drv = 1'b0;
  logic       pc_jump = 1'b0;
  logic       load_en = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [3:0] opcode;
  logic       zero_flag, bus_conflict;
  logic [7:0] bus_value;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  accbus_datapath i_accbus_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .ir_field_drv(ir_field_drv),
    .pc_jump(pc_jump), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .opcode(opcode), .zero_flag(zero_flag),
    .bus_conflict(bus_conflict), .bus_value(bus_value));

  // {strobe[9:0], ir_field_drv, pc_jump, bus during step, opcode after, zero after}
  localparam logic [24:0] PROG [17] = '{
    {10'h280, 2'b00, 8'h00, 4'h0, 1'b0},
    {10'h050, 2'b00, 8'h13, 4'h1, 1'b0},
    {10'h080, 2'b10, 8'h03, 4'h1, 1'b0},
    {10'h148, 2'b00, 8'h00, 4'h1, 1'b1},
    {10'h280, 2'b00, 8'h01, 4'h1, 1'b1},
    {10'h050, 2'b00, 8'hA5, 4'hA, 1'b1},
    {10'h000, 2'b11, 8'h05, 4'hA, 1'b1},
    {10'h280, 2'b00, 8'h05, 4'hA, 1'b1},
    {10'h050, 2'b00, 8'h16, 4'h1, 1'b1},
    {10'h080, 2'b10, 8'h06, 4'h1, 1'b1},
    {10'h148, 2'b00, 8'h2C, 4'h1, 1'b0},
    {10'h006, 2'b00, 8'h2C, 4'h1, 1'b0},
    {10'h009, 2'b00, 8'h58, 4'h1, 1'b0},
    {10'h280, 2'b00, 8'h06, 4'h1, 1'b0},
    {10'h050, 2'b00, 8'h2C, 4'h2, 1'b0},
    {10'h100, 2'b00, 8'h00, 4'h2, 1'b0},
    {10'h200, 2'b00, 8'h07, 4'h2, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] s, input logic irf, input logic pj);
    @(negedge clk);
    strobe = s; ir_field_drv = irf; pc_jump = pj;
    #2;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    strobe = '0; ir_field_drv = 1'b0; pc_jump = 1'b0; load_en = 1'b0;
  endtask

  task automatic poke(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = a; load_data = d;
    tick();
  endtask

  task automatic peek(input string tag, input logic [9:0] s, input logic irf,
                      input logic [7:0] exp);
    drive(s, irf, 1'b0);
    chk(tag, bus_value, exp);
    tick();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    poke(4'd0, 8'h13); poke(4'd1, 8'hA5); poke(4'd3, 8'h00);
    poke(4'd5, 8'h16); poke(4'd6, 8'h2C);
    tick();
    rst = 1'b0;
    chk("R1 opcode after reset", {4'h0, opcode}, 8'h00);
    chk("R1 zero after reset", {7'd0, zero_flag}, 8'h00);

    // R11 R10 R2 R5 R8: instruction stream built from strobes
    for (int i = 0; i < 17; i++) begin
      drive(PROG[i][24:15], PROG[i][14], PROG[i][13]);
      chk($sformatf("R11 step %0d bus", i), bus_value, PROG[i][12:5]);
      chk($sformatf("R3 step %0d no conflict", i), {7'd0, bus_conflict}, 8'h00);
      tick();
      chk($sformatf("R5 step %0d opcode", i), {4'h0, opcode}, {4'h0, PROG[i][4:1]});
      chk($sformatf("R8 step %0d zero", i), {7'd0, zero_flag}, {7'd0, PROG[i][0]});
    end

    // R9: adder wraps modulo 256 (0xB0 + 0x58)
    drive(10'h006, 1'b0, 1'b0); tick();
    drive(10'h009, 1'b0, 1'b0); tick();
    peek("R9 sum wrap", 10'h001, 1'b0, 8'h08);

    // R3: colliding drivers zero the bus; accumulator loads that zero
    drive(10'h20C, 1'b0, 1'b0);
    chk("R3 conflict flag", {7'd0, bus_conflict}, 8'h01);
    chk("R3 conflict bus", bus_value, 8'h00);
    tick();
    chk("R3 zero after conflicted load", {7'd0, zero_flag}, 8'h01);
    peek("R2 idle bus", 10'h000, 1'b0, 8'h00);

    // R1: reset clears registers, RAM survives
    @(negedge clk); rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk("R1 zero flag cleared", {7'd0, zero_flag}, 8'h00);
    chk("R1 opcode cleared", {4'h0, opcode}, 8'h00);
    peek("R1 acc cleared", 10'h004, 1'b0, 8'h00);
    peek("R1 pc cleared", 10'h200, 1'b0, 8'h00);
    peek("R1 temp cleared", 10'h001, 1'b0, 8'h00);
    peek("R1 ram kept", 10'h040, 1'b0, 8'h13);

    // R7: test port wins over strobed write (acc=0 on bus)
    @(negedge clk);
    strobe = 10'h024; load_en = 1'b1; load_addr = 4'd0; load_data = 8'h77;
    tick();
    peek("R7 port priority", 10'h040, 1'b0, 8'h77);

    // R4: pc load, wrap, load priority over increment
    poke(4'd0, 8'h0F);
    drive(10'h040, 1'b0, 1'b1); tick();
    peek("R4 pc loaded", 10'h200, 1'b0, 8'h0F);
    drive(10'h100, 1'b0, 1'b0); tick();
    peek("R4 pc wrap", 10'h200, 1'b0, 8'h00);
    drive(10'h140, 1'b0, 1'b1); tick();
    peek("R4 load beats increment", 10'h200, 1'b0, 8'h0F);

    // R6: strobed RAM write stores bus at MAR
    poke(4'd0, 8'h3C);
    drive(10'h048, 1'b0, 1'b0); tick();
    poke(4'd0, 8'h00);
    drive(10'h024, 1'b0, 1'b0); tick();
    peek("R6 ram write", 10'h040, 1'b0, 8'h3C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule